// File: doc/BRIEF.md
# Quadrature Edge-Sampling FSK Demodulator

This block recovers binary FSK data from the two limited square waves, in-phase (I) and quadrature (Q), that a zero-IF receiver produces. A tone above the local oscillator makes I lag Q. A tone below it makes I lead Q. The block finds the sign of that phase relation without measuring any frequency. Each time either channel toggles, it looks at the current level of the other channel. From that pair it makes a one-bit decision and loads it into a registered data output. A one-cycle strobe marks every decision. A full IF cycle therefore gives four decisions, which bounds the timing uncertainty of the recovered data to a quarter of an IF period.

Both limiter inputs are asynchronous to the system clock. They pass through flop synchronisers before edge detection. For low bit rates an optional post-filter, enabled by a control input, holds the output until several decisions in a row agree. This suppresses single-edge glitches caused by noise.

Top module: `fsk_quad_demod`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dataOut` and `dataStrobe` are 0 after that edge.
- R2: Every clock cycle in which exactly one synchronised channel changes level produces exactly one one-cycle pulse on `dataStrobe`, so one full quadrature IF cycle gives four strobes.
- R3: A change of the synchronised I level produces decision 1 when the new I level equals the current Q level (I rising with Q high, I falling with Q low), and 0 otherwise.
- R4: A change of the synchronised Q level produces decision 1 when the new Q level differs from the current I level (Q rising with I low, Q falling with I high), and 0 otherwise.
- R5: A steady quadrature input with I lagging Q (state order I,Q = 00, 01, 11, 10) gives `dataOut` = 1. With I leading Q (order 00, 10, 11, 01) it gives `dataOut` = 0.
- R6: A cycle in which both synchronised channels change together produces no strobe and leaves `dataOut` unchanged.
- R7: With the default two-stage synchronisers, an input toggle set up before rising edge k shows on `dataStrobe` and `dataOut` after edge k+2 and not before.
- R8: With `filtEn` low, every decision is loaded into `dataOut` at its strobe.
- R9: With `filtEn` high, `dataOut` takes a new value only when the current decision and the two before it (AGREE_CNT = 3) are equal. `dataStrobe` still pulses for every decision.
- R10: `dataOut` never changes in a cycle where `dataStrobe` is not also high (outside reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| iIn | input | 1 | Limited I-channel square wave, asynchronous |
| qIn | input | 1 | Limited Q-channel square wave, asynchronous |
| filtEn | input | 1 | 1 selects the agreement post-filter on the output |
| dataOut | output | 1 | Recovered data bit, registered |
| dataStrobe | output | 1 | One-cycle pulse for each decision |

## Verification
A raw input toggle reaches the outputs three rising edges later: two synchroniser stages, then the output register. The bench drives inputs on falling edges and samples on falling edges, so the latency test reads the outputs after the first, second and third rising edges and expects the strobe only at the third. For waveform runs, each quarter period lasts at least two clocks. After the last transition the bench waits four more clocks before it compares the strobe count and the final bit, so every pending decision has been registered. Filter and simultaneous-edge checks wait four clocks after each single input step, which is longer than the three-edge latency.

// File: rtl/fskq_pkg.sv
package fskq_pkg;

  // Edge and level information passed from the datapath to the control
  typedef struct packed {
    logic iEdge;
    logic qEdge;
    logic iLvl;
    logic qLvl;
  } edgeInfo_t;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic load;     // load bitVal into the output register
    logic bitVal;   // decision value
    logic strobe;   // a decision was made this cycle
  } ctrlStrobes_t;

  localparam int CH_I = 0;
  localparam int CH_Q = 1;
  localparam int NUM_CH = 2;

endpackage

// File: rtl/fskq_sync.sv
module fskq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fskq_datapath.sv
module fskq_datapath
  import fskq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         iIn,
  input  logic         qIn,
  input  ctrlStrobes_t ctrl,
  output edgeInfo_t    edges,
  output logic         dataOut,
  output logic         dataStrobe
);
  logic [NUM_CH-1:0] rawIn;
  logic [NUM_CH-1:0] lvl;
  logic [NUM_CH-1:0] lvlPrev;
  logic [NUM_CH-1:0] chEdge;

  assign rawIn[CH_I] = iIn;
  assign rawIn[CH_Q] = qIn;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    fskq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (rawIn[ch]),
      .q   (lvl[ch])
    );

    always_ff @(posedge clk) begin
      if (rst) lvlPrev[ch] <= 1'b0;
      else     lvlPrev[ch] <= lvl[ch];
    end

    assign chEdge[ch] = lvl[ch] ^ lvlPrev[ch];
  end

  always_comb begin
    edges.iEdge = chEdge[CH_I];
    edges.qEdge = chEdge[CH_Q];
    edges.iLvl  = lvl[CH_I];
    edges.qLvl  = lvl[CH_Q];
  end

  // Output register and strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut    <= 1'b0;
      dataStrobe <= 1'b0;
    end else begin
      dataStrobe <= ctrl.strobe;
      if (ctrl.load) dataOut <= ctrl.bitVal;
    end
  end
endmodule

// File: rtl/fskq_control.sv
module fskq_control
  import fskq_pkg::*;
#(
  parameter int AGREE_CNT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         filtEn,
  input  edgeInfo_t    edges,
  output ctrlStrobes_t ctrl
);
  localparam int CNT_W = $clog2(AGREE_CNT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(AGREE_CNT);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             valid;
  logic             decBit;
  logic             lastBit, lastNext;
  logic [CNT_W-1:0] runCnt, runNext;

  always_comb begin
    // exactly one channel moved: a decision is possible
    valid  = edges.iEdge ^ edges.qEdge;
    // I edge: 1 when levels match; Q edge: 1 when levels differ
    decBit = edges.qEdge ? (edges.iLvl ^ edges.qLvl)
                         : ~(edges.iLvl ^ edges.qLvl);
    runNext  = runCnt;
    lastNext = lastBit;
    if (valid) begin
      lastNext = decBit;
      if (decBit == lastBit && runCnt != '0) begin
        if (runCnt < CNT_MAX) runNext = runCnt + CNT_ONE;
      end else begin
        runNext = CNT_ONE;
      end
    end
    ctrl.strobe = valid;
    ctrl.bitVal = decBit;
    ctrl.load   = valid && (!filtEn || runNext >= CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt  <= '0;
      lastBit <= 1'b0;
    end else begin
      runCnt  <= runNext;
      lastBit <= lastNext;
    end
  end
endmodule

// File: rtl/fsk_quad_demod.sv
module fsk_quad_demod
  import fskq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AGREE_CNT   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic iIn,
  input  logic qIn,
  input  logic filtEn,
  output logic dataOut,
  output logic dataStrobe
);
  edgeInfo_t    edges;
  ctrlStrobes_t ctrl;

  fskq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .iIn        (iIn),
    .qIn        (qIn),
    .ctrl       (ctrl),
    .edges      (edges),
    .dataOut    (dataOut),
    .dataStrobe (dataStrobe)
  );

  fskq_control #(.AGREE_CNT(AGREE_CNT)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .filtEn (filtEn),
    .edges  (edges),
    .ctrl   (ctrl)
  );
endmodule

// File: rtl/fskq_checker.sv
module fskq_checker (
  input logic clk,
  input logic rst,
  input logic filtEn,
  input logic iEdge,
  input logic qEdge,
  input logic iLvl,
  input logic qLvl,
  input logic dataOut,
  input logic dataStrobe
);
  // R6: simultaneous change gives no strobe
  p_both_edges_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (iEdge && qEdge) |=> !dataStrobe);

  // R2: a single-channel change gives a strobe
  p_single_edge_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    (iEdge ^ qEdge) |=> dataStrobe);

  // R3 with R8: I-edge decision reaches the output unfiltered
  p_i_edge_rule_r3: assert property (@(posedge clk) disable iff (rst)
    (iEdge && !qEdge && !filtEn) |=> (dataOut == ($past(iLvl) == $past(qLvl))));

  // R4 with R8: Q-edge decision reaches the output unfiltered
  p_q_edge_rule_r4: assert property (@(posedge clk) disable iff (rst)
    (qEdge && !iEdge && !filtEn) |=> (dataOut == ($past(iLvl) != $past(qLvl))));

  // R10: output moves only together with a strobe
  p_change_needs_strobe_r10: assert property (@(posedge clk) disable iff (rst || $past(rst))
    !$stable(dataOut) |-> dataStrobe);
endmodule

bind fsk_quad_demod fskq_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .filtEn     (filtEn),
  .iEdge      (edges.iEdge),
  .qEdge      (edges.qEdge),
  .iLvl       (edges.iLvl),
  .qLvl       (edges.qLvl),
  .dataOut    (dataOut),
  .dataStrobe (dataStrobe)
);

// File: tb/tb_fsk_quad_demod.sv
module tb_fsk_quad_demod;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // fields: leadI, quarter (clocks), IF cycles, filtEn
  localparam int VEC [NVEC][4] = '{
    '{1, 2, 6, 0},
    '{0, 3, 6, 0},
    '{1, 5, 4, 1},
    '{0, 8, 4, 1},
    '{1, 4, 5, 0},
    '{0, 2, 8, 1}
  };

  logic clk = 1'b0;
  logic rst;
  logic iIn, qIn, filtEn;
  logic dataOut, dataStrobe;

  int checks = 0;
  int errors = 0;
  int strobeCnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsk_quad_demod dut (
    .clk        (clk),
    .rst        (rst),
    .iIn        (iIn),
    .qIn        (qIn),
    .filtEn     (filtEn),
    .dataOut    (dataOut),
    .dataStrobe (dataStrobe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance n falling edges, counting strobes seen
  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (dataStrobe) strobeCnt++;
    end
  endtask

  task automatic runWave(input int leadI, input int quarter, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      for (int ph = 0; ph < 4; ph++) begin
        if (leadI != 0) begin
          case (ph)
            0: begin iIn = 1; qIn = 0; end
            1: begin iIn = 1; qIn = 1; end
            2: begin iIn = 0; qIn = 1; end
            default: begin iIn = 0; qIn = 0; end
          endcase
        end else begin
          case (ph)
            0: begin iIn = 0; qIn = 1; end
            1: begin iIn = 1; qIn = 1; end
            2: begin iIn = 1; qIn = 0; end
            default: begin iIn = 0; qIn = 0; end
          endcase
        end
        tick(quarter);
      end
    end
    tick(4);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    rst = 1'b1; iIn = 0; qIn = 0; filtEn = 0;
    tick(4);
    // R1: reset state
    check(dataOut == 0, "R1 dataOut in reset", dataOut, 0);
    check(dataStrobe == 0, "R1 strobe in reset", dataStrobe, 0);
    rst = 1'b0;
    tick(3);

    // Table of waveforms: R2 (strobe count), R5 (bit), R8/R9 via filtEn
    for (int v = 0; v < NVEC; v++) begin
      filtEn = VEC[v][3][0];
      strobeCnt = 0;
      runWave(VEC[v][0], VEC[v][1], VEC[v][2]);
      check(dataOut == (VEC[v][0] == 0), "R5 steady output bit",
            dataOut, (VEC[v][0] == 0));
      check(strobeCnt == 4 * VEC[v][2], "R2 strobes per IF cycle",
            strobeCnt, 4 * VEC[v][2]);
    end

    // R9: filter on, output 1, state 00; step through decisions 0,0,0
    filtEn = 1;
    runWave(0, 3, 2);
    check(dataOut == 1, "R9 preset to 1", dataOut, 1);
    strobeCnt = 0;
    iIn = 1; qIn = 0; tick(4);          // I rises, Q low -> 0 (run 1)
    check(dataOut == 1, "R9 held after one disagreeing decision", dataOut, 1);
    qIn = 1; tick(4);                   // Q rises, I high -> 0 (run 2)
    check(dataOut == 1, "R9 held after two disagreeing decisions", dataOut, 1);
    iIn = 0; tick(4);                   // I falls, Q high -> 0 (run 3)
    check(dataOut == 0, "R9 switched after three agreeing decisions", dataOut, 0);
    check(strobeCnt == 3, "R9 strobe per decision", strobeCnt, 3);
    qIn = 0; tick(4);                   // Q falls, I low -> 0

    // R9 glitch: decisions 1 then 0 do not move the filtered output
    qIn = 1; tick(4);                   // Q rises, I low -> 1
    check(dataOut == 0, "R9 single glitch decision ignored", dataOut, 0);
    qIn = 0; tick(4);                   // Q falls, I low -> 0
    check(dataOut == 0, "R9 output after glitch", dataOut, 0);

    // R7 latency and R4/R8 with filter off
    filtEn = 0;
    strobeCnt = 0;
    qIn = 1;                            // Q rises, I low -> 1
    @(negedge clk);
    check(dataStrobe == 0 && dataOut == 0, "R7 no output after 1 edge", dataStrobe, 0);
    @(negedge clk);
    check(dataStrobe == 0 && dataOut == 0, "R7 no output after 2 edges", dataStrobe, 0);
    @(negedge clk);
    check(dataStrobe == 1, "R7 strobe after 3 edges", dataStrobe, 1);
    check(dataOut == 1, "R4 Q rising with I low gives 1", dataOut, 1);
    tick(1);
    check(dataStrobe == 0, "R2 strobe lasts one cycle", dataStrobe, 0);
    iIn = 1; tick(4);                   // I rises, Q high -> 1
    check(dataOut == 1, "R3 I rising with Q high gives 1", dataOut, 1);
    qIn = 0; tick(4);                   // Q falls, I high -> 1
    check(dataOut == 1, "R4 Q falling with I high gives 1", dataOut, 1);
    iIn = 0; tick(4);                   // I falls, Q low -> 1
    check(dataOut == 1, "R3 I falling with Q low gives 1", dataOut, 1);
    iIn = 1; tick(4);                   // I rises, Q low -> 0
    check(dataOut == 0, "R8 unfiltered follows single decision", dataOut, 0);
    iIn = 0; tick(4);                   // I falls, Q low -> 1
    check(dataOut == 1, "R8 unfiltered follows next decision", dataOut, 1);

    // R6: both channels together, twice
    strobeCnt = 0;
    iIn = 1; qIn = 1; tick(6);
    check(strobeCnt == 0, "R6 no strobe on joint change", strobeCnt, 0);
    check(dataOut == 1, "R6 output kept on joint change", dataOut, 1);
    iIn = 0; qIn = 0; tick(6);
    check(strobeCnt == 0, "R6 no strobe on joint return", strobeCnt, 0);

    // R1: reset mid-operation clears the output
    rst = 1'b1; tick(2);
    check(dataOut == 0 && dataStrobe == 0, "R1 reset clears output", dataOut, 0);
    rst = 1'b0; tick(2);

    finish();
  end
endmodule